// File: doc/BRIEF.md
# Stereo Digital Volume Attenuator

This block sits in the audio path of a streaming sink, between the stage that unpacks received audio samples and the interpolation filter. It scales 16-bit signed stereo samples by a gain taken from a table of whole-decibel attenuations, from 0 dB down to -64 dB. A small control port carries volume and mute settings that have already been decoded from host requests.

Three attenuations are kept: one master and one for each channel. The gain a channel receives follows the sum of the master and channel attenuations. Mute exists only at master level, and a mute aimed at one channel is refused through a reject pulse; the request engine decides how to answer the host. The applied gain never jumps. On each sample strobe it moves one table step toward its target, so a mute fades out, an unmute fades back in, and a large volume change turns into a short ramp.

Top module: `stereo_vol_atten`

## Requirements
- R1: After reset the master and both channel attenuations are 0 dB, mute is off, both applied indices are 0, and `outValid`, `ctrlReject`, `outLeft` and `outRight` are 0.
- R2: For a sample strobe in cycle t, `outValid` is high in cycle t+1 only. Each output then equals sat16(floor((x*G + 16384) / 32768)), where x is the input sample and G is the gain at the channel's applied index. The gain is G(n) = round(32768 * 10^(-n/20)) for n in 0..64, and G(65) = 0.
- R3: `ctrlTarget` encodes 0 = master, 1 = left, 2 = right, 3 = reserved. A volume write to one channel changes only that channel's gain.
- R4: A channel's target index is min(master + channel attenuation, 64). An attenuation value above 64 in a write is stored as 64.
- R5: On each sample strobe, each applied index moves by exactly one step toward its target, or stays put if it is already there. The output for that strobe uses the index as it was before the step.
- R6: A write with `ctrlIsMute`=1 to the master target sets mute to `ctrlMute`. While mute is on, both targets are index 65 (gain 0). Clearing mute makes the indices walk back to their volume targets at the same rate.
- R7: A mute write to the left or right target, or any write to the reserved target, leaves all settings unchanged. Such a write raises `ctrlReject` for exactly the cycle after it. Accepted writes keep `ctrlReject` low.
- R8: Without a sample strobe, the applied indices and the output samples hold their values and `outValid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlValid | input | 1 | Control write strobe |
| ctrlTarget | input | 2 | Write target: 0 master, 1 left, 2 right, 3 reserved |
| ctrlIsMute | input | 1 | 1 = mute write, 0 = volume write |
| ctrlAtten | input | 7 | Attenuation in dB for volume writes |
| ctrlMute | input | 1 | Mute value for mute writes |
| ctrlReject | output | 1 | Pulse one cycle after an unsupported write |
| sampleValid | input | 1 | Sample pair strobe |
| sampleLeft | input | 16 | Left input sample, two's complement |
| sampleRight | input | 16 | Right input sample, two's complement |
| outValid | output | 1 | Scaled pair valid, one cycle after the strobe |
| outLeft | output | 16 | Scaled left sample |
| outRight | output | 16 | Scaled right sample |

## Verification
The hardest states to reach are the ends of the index range. The clamp at 64 dB can only be hit by a master and channel sum that exceeds it, and the mute floor at index 65 lies past the last table entry. Neither shows at the ports unless enough strobes arrive for the ramp to get there. The stimulus therefore sets master 10 dB and right 60 dB, and then mutes. Between these steps it sends runs of 70 or more strobes while a reference model tracks each index. It also slips the rejected writes into the middle of a ramp, so any disturbance of the settings would show up in the very next samples.

// File: rtl/vol_atten_pkg.sv
package vol_atten_pkg;

  typedef enum logic [1:0] {
    TGT_MASTER = 2'd0,
    TGT_LEFT   = 2'd1,
    TGT_RIGHT  = 2'd2,
    TGT_RSVD   = 2'd3
  } volTarget_e;

  // per-channel ramp strobes from control to datapath; bit 0 left, bit 1 right
  typedef struct packed {
    logic [1:0] up;
    logic [1:0] down;
  } stepCmd_t;

  // elaboration-time gain entry: round(2^fracBits * 10^(-n/20)), zero past maxIdx
  function automatic int gainCode(int n, int maxIdx, int fracBits);
    real v;
    if (n > maxIdx) return 0;
    v = (2.0 ** fracBits) * (10.0 ** (-real'(n) / 20.0));
    return $rtoi(v + 0.5);
  endfunction

endpackage

// File: rtl/vol_ctrl.sv
module vol_ctrl
  import vol_atten_pkg::*;
#(
  parameter int IDX_W     = 7,
  parameter int ATTEN_MAX = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctrlValid,
  input  logic [1:0]       ctrlTarget,
  input  logic             ctrlIsMute,
  input  logic [IDX_W-1:0] ctrlAtten,
  input  logic             ctrlMute,
  input  logic             sampleValid,
  input  logic [IDX_W-1:0] curIdx [2],
  output logic             ctrlReject,
  output stepCmd_t         stepCmd
);
  localparam int MUTE_IDX = ATTEN_MAX + 1;

  logic [IDX_W-1:0] masterAtt;
  logic [IDX_W-1:0] chanAtt [2];
  logic             muteOn;
  logic             badReq;
  logic [IDX_W-1:0] clampedAtt;
  logic [1:0]       upV, downV;

  assign badReq = ctrlValid &&
                  ((ctrlTarget == TGT_RSVD) || (ctrlIsMute && ctrlTarget != TGT_MASTER));
  assign clampedAtt = (ctrlAtten > IDX_W'(ATTEN_MAX)) ? IDX_W'(ATTEN_MAX) : ctrlAtten;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      masterAtt  <= '0;
      chanAtt[0] <= '0;
      chanAtt[1] <= '0;
      muteOn     <= 1'b0;
      ctrlReject <= 1'b0;
    end else begin
      ctrlReject <= badReq;
      if (ctrlValid && !badReq) begin
        if (ctrlIsMute) begin
          muteOn <= ctrlMute;
        end else begin
          case (ctrlTarget)
            TGT_MASTER: masterAtt  <= clampedAtt;
            TGT_LEFT:   chanAtt[0] <= clampedAtt;
            TGT_RIGHT:  chanAtt[1] <= clampedAtt;
            default:    ;
          endcase
        end
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_chan
    logic [IDX_W:0]   sumAtt;
    logic [IDX_W-1:0] effAtt;
    logic [IDX_W-1:0] tgtIdx;
    assign sumAtt = {1'b0, masterAtt} + {1'b0, chanAtt[g]};
    assign effAtt = (sumAtt > (IDX_W+1)'(ATTEN_MAX)) ? IDX_W'(ATTEN_MAX) : sumAtt[IDX_W-1:0];
    assign tgtIdx = muteOn ? IDX_W'(MUTE_IDX) : effAtt;
    assign upV[g]   = sampleValid && (curIdx[g] < tgtIdx);
    assign downV[g] = sampleValid && (curIdx[g] > tgtIdx);

    // stored channel attenuation never exceeds the table end (R4)
    p_chan_clamp_r4: assert property (@(posedge clk) disable iff (!rstN)
      chanAtt[g] <= IDX_W'(ATTEN_MAX));
  end

  assign stepCmd = '{up: upV, down: downV};

  // unsupported write raises the reject flag the next cycle (R7)
  p_reject_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    badReq |=> ctrlReject);
  // unsupported write leaves every setting as it was (R7)
  p_reject_nochange_r7: assert property (@(posedge clk) disable iff (!rstN)
    badReq |=> ($stable(masterAtt) && $stable(chanAtt[0]) && $stable(chanAtt[1]) && $stable(muteOn)));
  // no ramp strobe without a sample strobe (R8)
  p_no_step_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |-> (stepCmd.up == 2'b00 && stepCmd.down == 2'b00));

endmodule

// File: rtl/vol_datapath.sv
module vol_chan_scale #(
  parameter int SAMPLE_W = 16,
  parameter int GAIN_W   = 16
) (
  input  logic signed [SAMPLE_W-1:0] sampleIn,
  input  logic        [GAIN_W-1:0]   gain,
  output logic signed [SAMPLE_W-1:0] sampleOut
);
  localparam int FRAC = GAIN_W - 1;
  localparam int PW   = SAMPLE_W + GAIN_W + 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) << (FRAC - 1);
  localparam logic signed [PW-1:0] POS_LIM = PW'((2 ** (SAMPLE_W - 1)) - 1);
  localparam logic signed [PW-1:0] NEG_LIM = -(PW'(2 ** (SAMPLE_W - 1)));

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rounded;

  always_comb begin
    prod    = $signed(sampleIn) * $signed({1'b0, gain});
    rounded = (prod + HALF) >>> FRAC;
    if (rounded > POS_LIM)      sampleOut = POS_LIM[SAMPLE_W-1:0];
    else if (rounded < NEG_LIM) sampleOut = NEG_LIM[SAMPLE_W-1:0];
    else                        sampleOut = rounded[SAMPLE_W-1:0];
  end
endmodule

module vol_datapath
  import vol_atten_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int GAIN_W    = 16,
  parameter int IDX_W     = 7,
  parameter int ATTEN_MAX = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sampleValid,
  input  logic signed [SAMPLE_W-1:0] sampleIn [2],
  input  stepCmd_t                   stepCmd,
  output logic        [IDX_W-1:0]    curIdx [2],
  output logic                       outValid,
  output logic signed [SAMPLE_W-1:0] sampleOut [2]
);
  localparam int MUTE_IDX = ATTEN_MAX + 1;

  logic [GAIN_W-1:0] gainRom [MUTE_IDX+1];

  for (genvar i = 0; i <= MUTE_IDX; i++) begin : g_rom
    assign gainRom[i] = GAIN_W'(gainCode(i, ATTEN_MAX, GAIN_W - 1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= sampleValid;
  end

  for (genvar g = 0; g < 2; g++) begin : g_chan
    logic signed [SAMPLE_W-1:0] scaled;

    vol_chan_scale #(.SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W)) u_scale (
      .sampleIn (sampleIn[g]),
      .gain     (gainRom[curIdx[g]]),
      .sampleOut(scaled)
    );

    always_ff @(posedge clk) begin
      if (!rstN) begin
        curIdx[g]    <= '0;
        sampleOut[g] <= '0;
      end else if (sampleValid) begin
        sampleOut[g] <= scaled;
        if (stepCmd.up[g])        curIdx[g] <= curIdx[g] + 1'b1;
        else if (stepCmd.down[g]) curIdx[g] <= curIdx[g] - 1'b1;
      end
    end

    // index moves at most one step per strobe (R5)
    p_step_size_r5: assert property (@(posedge clk) disable iff (!rstN)
      sampleValid |=> (curIdx[g] == $past(curIdx[g]) ||
                       curIdx[g] == $past(curIdx[g]) + 1'b1 ||
                       curIdx[g] == $past(curIdx[g]) - 1'b1));
    // index and output hold without a strobe (R8)
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
      !sampleValid |=> ($stable(curIdx[g]) && $stable(sampleOut[g])));
    // index stays inside the table plus the mute floor (R4)
    p_idx_range_r4: assert property (@(posedge clk) disable iff (!rstN)
      curIdx[g] <= IDX_W'(MUTE_IDX));
    // at the mute floor the output is silent (R6)
    p_mute_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
      (sampleValid && curIdx[g] == IDX_W'(MUTE_IDX)) |=> (sampleOut[g] == '0));
  end

  // valid follows the strobe by exactly one cycle (R2)
  p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> outValid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !outValid);

endmodule

// File: rtl/stereo_vol_atten.sv
module stereo_vol_atten
  import vol_atten_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int GAIN_W    = 16,
  parameter int ATTEN_MAX = 64,
  parameter int IDX_W     = $clog2(ATTEN_MAX + 2)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlValid,
  input  logic [1:0]          ctrlTarget,
  input  logic                ctrlIsMute,
  input  logic [IDX_W-1:0]    ctrlAtten,
  input  logic                ctrlMute,
  output logic                ctrlReject,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleLeft,
  input  logic [SAMPLE_W-1:0] sampleRight,
  output logic                outValid,
  output logic [SAMPLE_W-1:0] outLeft,
  output logic [SAMPLE_W-1:0] outRight
);
  stepCmd_t                   stepCmd;
  logic        [IDX_W-1:0]    curIdx [2];
  logic signed [SAMPLE_W-1:0] sampleIn [2];
  logic signed [SAMPLE_W-1:0] sampleOut [2];

  assign sampleIn[0] = sampleLeft;
  assign sampleIn[1] = sampleRight;
  assign outLeft     = sampleOut[0];
  assign outRight    = sampleOut[1];

  vol_ctrl #(.IDX_W(IDX_W), .ATTEN_MAX(ATTEN_MAX)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlValid  (ctrlValid),
    .ctrlTarget (ctrlTarget),
    .ctrlIsMute (ctrlIsMute),
    .ctrlAtten  (ctrlAtten),
    .ctrlMute   (ctrlMute),
    .sampleValid(sampleValid),
    .curIdx     (curIdx),
    .ctrlReject (ctrlReject),
    .stepCmd    (stepCmd)
  );

  vol_datapath #(
    .SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .IDX_W(IDX_W), .ATTEN_MAX(ATTEN_MAX)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .sampleIn   (sampleIn),
    .stepCmd    (stepCmd),
    .curIdx     (curIdx),
    .outValid   (outValid),
    .sampleOut  (sampleOut)
  );

endmodule

// File: tb/stereo_vol_atten_bench.sv
module stereo_vol_atten_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ctrlValid = 1'b0;
  logic [1:0]  ctrlTarget = '0;
  logic        ctrlIsMute = 1'b0;
  logic [6:0]  ctrlAtten = '0;
  logic        ctrlMute = 1'b0;
  logic        ctrlReject;
  logic        sampleValid = 1'b0;
  logic [15:0] sampleLeft = '0;
  logic [15:0] sampleRight = '0;
  logic        outValid;
  logic [15:0] outLeft, outRight;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  int mAtt = 0, lAtt = 0, rAtt = 0;
  bit mute = 1'b0;
  int curL = 0, curR = 0;

  typedef struct { logic [15:0] l; logic [15:0] r; string tag; } item_t;
  item_t expQ[$];

  always #5 clk = ~clk;

  stereo_vol_atten u_stereo_vol_atten (
    .clk(clk), .rstN(rstN),
    .ctrlValid(ctrlValid), .ctrlTarget(ctrlTarget), .ctrlIsMute(ctrlIsMute),
    .ctrlAtten(ctrlAtten), .ctrlMute(ctrlMute), .ctrlReject(ctrlReject),
    .sampleValid(sampleValid), .sampleLeft(sampleLeft), .sampleRight(sampleRight),
    .outValid(outValid), .outLeft(outLeft), .outRight(outRight)
  );

  function automatic int refGain(int n);
    if (n >= 65) return 0;
    return $rtoi(32768.0 * $pow(10.0, -n / 20.0) + 0.5);
  endfunction

  function automatic logic [15:0] refScale(logic [15:0] x, int n);
    longint p, q;
    p = longint'($signed(x)) * refGain(n);
    q = (p + 16384) >>> 15;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q[15:0];
  endfunction

  function automatic int refTarget(int chAtt);
    int s;
    if (mute) return 65;
    s = mAtt + chAtt;
    return (s > 64) ? 64 : s;
  endfunction

  function automatic int refStep(int cur, int tgt);
    if (cur < tgt) return cur + 1;
    if (cur > tgt) return cur - 1;
    return cur;
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic sendSample(logic [15:0] l, logic [15:0] r, string tag);
    item_t it;
    @(negedge clk);
    sampleValid = 1'b1; sampleLeft = l; sampleRight = r;
    it.l = refScale(l, curL); it.r = refScale(r, curR); it.tag = tag;
    expQ.push_back(it);
    curL = refStep(curL, refTarget(lAtt));
    curR = refStep(curR, refTarget(rAtt));
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic sendRun(int n, logic [15:0] l, logic [15:0] r, string tag);
    for (int i = 0; i < n; i++) sendSample(l, r, tag);
  endtask

  // target 0 master, 1 left, 2 right, 3 reserved
  task automatic writeCtrl(int tgt, bit isMute, int att, bit mv, bit expRej, string tag);
    @(negedge clk);
    ctrlValid = 1'b1; ctrlTarget = 2'(tgt); ctrlIsMute = isMute;
    ctrlAtten = 7'(att); ctrlMute = mv;
    @(negedge clk);
    ctrlValid = 1'b0;
    check(ctrlReject == expRej, tag, ctrlReject, expRej);
    if (!expRej) begin
      int a;
      a = (att > 64) ? 64 : att;
      if (isMute) mute = mv;
      else if (tgt == 0) mAtt = a;
      else if (tgt == 1) lAtt = a;
      else if (tgt == 2) rAtt = a;
    end
    @(negedge clk);
    check(ctrlReject == 1'b0, {tag, " pulse width"}, ctrlReject, 0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R2 unexpected outValid", 1, 0);
      end else begin
        item_t it;
        it = expQ.pop_front();
        check(outLeft == it.l, {it.tag, " left"}, $signed(outLeft), $signed(it.l));
        check(outRight == it.r, {it.tag, " right"}, $signed(outRight), $signed(it.r));
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(outValid == 1'b0, "R1 outValid", outValid, 0);
    check(ctrlReject == 1'b0, "R1 ctrlReject", ctrlReject, 0);
    check(outLeft == 16'd0 && outRight == 16'd0, "R1 outputs", outLeft, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid after reset", outValid, 0);

    // R2: unity gain, extremes
    sendSample(16'd12345, 16'hB1E0, "R2 unity");
    sendSample(16'h7FFF, 16'h8000, "R2 extremes");
    sendSample(16'h0001, 16'hFFFF, "R2 small");

    // R3 + R5: left only ramps to 6 dB
    writeCtrl(1, 0, 6, 0, 0, "R3 left write");
    sendRun(8, 16'h4000, 16'h4000, "R3 R5 left ramp");

    // R4: sum beyond 64 clamps
    writeCtrl(0, 0, 10, 0, 0, "R4 master write");
    writeCtrl(2, 0, 60, 0, 0, "R4 right write");
    sendRun(70, 16'h7FFF, 16'h8000, "R4 clamp ramp");

    // R4: stored value above 64 clamps
    writeCtrl(1, 0, 100, 0, 0, "R4 big left write");
    writeCtrl(0, 0, 0, 0, 0, "R4 master zero");
    sendRun(20, 16'h7FFF, 16'h2345, "R4 big value ramp");

    // R7: rejected writes in the middle of a ramp
    writeCtrl(1, 1, 0, 1, 1, "R7 mute left");
    writeCtrl(2, 1, 0, 1, 1, "R7 mute right");
    writeCtrl(3, 0, 0, 0, 1, "R7 reserved volume");
    writeCtrl(3, 1, 0, 1, 1, "R7 reserved mute");
    sendRun(50, 16'h7FFF, 16'hC000, "R7 state kept");

    // R6: master mute fade out, then fade back in
    writeCtrl(1, 0, 3, 0, 0, "R6 left preset");
    writeCtrl(2, 0, 0, 0, 0, "R6 right preset");
    sendRun(70, 16'h7FFF, 16'h8000, "R3 R5 settle");
    writeCtrl(0, 1, 0, 1, 0, "R6 mute on");
    sendRun(70, 16'h7FFF, 16'h8000, "R6 fade out");
    writeCtrl(0, 1, 0, 0, 0, "R6 mute off");
    sendRun(70, 16'h7FFF, 16'h8000, "R6 fade in");

    // R8: no strobe, nothing moves
    begin
      logic [15:0] hl, hr;
      @(negedge clk);
      hl = outLeft; hr = outRight;
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        check(outValid == 1'b0, "R8 idle valid", outValid, 0);
        check(outLeft == hl && outRight == hr, "R8 idle hold", outLeft, hl);
      end
    end
    writeCtrl(1, 0, 20, 0, 0, "R8 write while idle");
    repeat (4) @(negedge clk);
    sendSample(16'h7FFF, 16'h7FFF, "R8 R5 first after idle");
    sendSample(16'h7FFF, 16'h7FFF, "R8 R5 second after idle");

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R2 all outputs seen", expQ.size(), 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule